// File: doc/BRIEF.md
# Variable-Block Carry-Skip Adder

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum with a carry-out. It has no clock and no reset: the outputs follow the current inputs only. Inside, the operand bits are cut into a chain of groups. Each group passes a carry from bit to bit within itself. Each group also reports whether every one of its bits would pass a carry straight through.

When a group passes every bit through, a two-way selector hands the group's incoming carry directly to the next group and does not wait for the ripple. Otherwise the selector forwards the carry that rippled out of the group's top bit. The group widths come from a parameter array. The default is narrow at both ends and wide in the middle, because the slowest route starts with a ripple in the lowest group, skips across the middle groups and ends with a ripple in the highest group. Elaboration stops if the widths do not add up to the operand width.

Top module: `skip_adder`

## Requirements
- R1: For every input, {carryOut, sum} equals the 17-bit value opA + opB + carryIn.
- R2: opA = 16'hFFFF, opB = 16'h0000 with carryIn = 1 gives sum 16'h0000 and carryOut 1, so a single carry crosses every group.
- R3: A group's propagate flag is 1 exactly when opA and opB differ in every bit position of that group.
- R4: When a group's propagate flag is 1, the carry it hands to the next group equals the carry it received.
- R5: When a group's propagate flag is 0, the carry it hands on is the carry rippled out of its most significant bit, so a generate inside the group sets it and a kill inside the group clears it, whatever the carry that came in.
- R6: The lowest group receives carryIn, and carryOut is the carry handed on by the highest group.
- R7: Group widths default to 2, 3, 4, 4, 3 bits, listed from the least significant group up. Elaboration fails when the widths do not sum to the operand width.
- R8: The outputs depend only on the present inputs. A new input pattern shows its result with no clock edge, and the previous pattern has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
Zero plus zero, and random operand pairs tried with both carry-in values, show that the arithmetic holds across ordinary mixtures of generate, kill and propagate bits. All-ones plus a carry-in drives one carry through every skip selector at once. Operands that make exactly one group fully propagating, with a carry generated just below that group, show whether that group's selector forwards the incoming carry correctly. Operands that place a generate or a kill at the top bit of a group, with the opposite carry arriving from below, show that a group which does not fully propagate uses its ripple result and ignores the carry that came in.

// File: rtl/skip_pkg.sv
package skip_pkg;

  // Status that a group's ripple logic hands to its skip selector
  typedef struct packed {
    logic allProp;    // every bit of the group propagates
    logic rippleOut;  // carry rippled out of the group's top bit
  } grpStatus_t;

endpackage

// File: rtl/skip_bit.sv
module skip_bit (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic prop,
  output logic sum,
  output logic cout
);
  logic gen;

  always_comb begin
    gen  = a & b;
    prop = a ^ b;
    sum  = prop ^ cin;
    cout = gen | (prop & cin);
  end
endmodule

// File: rtl/skip_group.sv
module skip_group
  import skip_pkg::*;
#(
  parameter int SIZE = 4
) (
  input  logic [SIZE-1:0] a,
  input  logic [SIZE-1:0] b,
  input  logic            cin,
  output logic [SIZE-1:0] sum,
  output grpStatus_t      status
);
  logic [SIZE:0]   chain;
  logic [SIZE-1:0] bitProp;

  assign chain[0] = cin;

  for (genvar i = 0; i < SIZE; i++) begin : g_bit
    skip_bit u_bit (
      .a    (a[i]),
      .b    (b[i]),
      .cin  (chain[i]),
      .prop (bitProp[i]),
      .sum  (sum[i]),
      .cout (chain[i+1])
    );
  end

  always_comb begin
    status.allProp   = &bitProp;
    status.rippleOut = chain[SIZE];
  end
endmodule

// File: rtl/skip_select.sv
module skip_select
  import skip_pkg::*;
(
  input  logic       cin,
  input  grpStatus_t status,
  output logic       cout
);
  always_comb begin
    cout = status.allProp ? cin : status.rippleOut;
  end
endmodule

// File: rtl/skip_adder.sv
module skip_adder
  import skip_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int NUM_GROUPS = 5,
  parameter int GROUP_SIZES [NUM_GROUPS] = '{2, 3, 4, 4, 3}
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  function automatic int offsetOf(input int grp);
    int acc;
    acc = 0;
    for (int i = 0; i < grp; i++) acc += GROUP_SIZES[i];
    return acc;
  endfunction

  localparam int TOTAL_BITS = offsetOf(NUM_GROUPS);

  if (TOTAL_BITS != WIDTH) begin : g_bad_sizes
    $error("skip_adder: group sizes add to %0d, operand width is %0d", TOTAL_BITS, WIDTH);
  end

  logic [NUM_GROUPS:0]   grpCarry;
  logic [NUM_GROUPS-1:0] grpProp;
  grpStatus_t            grpStat [NUM_GROUPS];

  assign grpCarry[0] = carryIn;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = offsetOf(g);
    localparam int SZ = GROUP_SIZES[g];

    skip_group #(.SIZE(SZ)) u_grp (
      .a      (opA[LO +: SZ]),
      .b      (opB[LO +: SZ]),
      .cin    (grpCarry[g]),
      .sum    (sum[LO +: SZ]),
      .status (grpStat[g])
    );

    skip_select u_sel (
      .cin    (grpCarry[g]),
      .status (grpStat[g]),
      .cout   (grpCarry[g+1])
    );

    assign grpProp[g] = grpStat[g].allProp;
  end

  assign carryOut = grpCarry[NUM_GROUPS];
endmodule

// File: rtl/skip_adder_chk.sv
module skip_adder_chk #(
  parameter int WIDTH      = 16,
  parameter int NUM_GROUPS = 5,
  parameter int GROUP_SIZES [NUM_GROUPS] = '{2, 3, 4, 4, 3}
) (
  input logic [WIDTH-1:0]      opA,
  input logic [WIDTH-1:0]      opB,
  input logic                  carryIn,
  input logic [WIDTH-1:0]      sum,
  input logic                  carryOut,
  input logic [NUM_GROUPS:0]   grpCarry,
  input logic [NUM_GROUPS-1:0] grpProp
);
  function automatic int chkOffset(input int grp);
    int acc;
    acc = 0;
    for (int i = 0; i < grp; i++) acc += GROUP_SIZES[i];
    return acc;
  endfunction

  logic [WIDTH:0] refTotal;
  logic [WIDTH-1:0] diffBits;

  always_comb begin
    refTotal = (WIDTH+1)'(opA) + (WIDTH+1)'(opB) + (WIDTH+1)'(carryIn);
    diffBits = opA ^ opB;
    a_r1_total_matches: assert ({carryOut, sum} == refTotal)
      else $error("R1 result mismatch");
    a_r6_first_carry: assert (grpCarry[0] == carryIn)
      else $error("R6 first group carry");
    a_r6_last_carry: assert (carryOut == grpCarry[NUM_GROUPS])
      else $error("R6 carry-out source");
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    localparam int LO = chkOffset(g);
    localparam int SZ = GROUP_SIZES[g];

    always_comb begin
      a_r3_group_prop: assert (grpProp[g] == (&diffBits[LO +: SZ]))
        else $error("R3 propagate flag, group %0d", g);
      if (grpProp[g]) begin
        a_r4_skip_passes: assert (grpCarry[g+1] == grpCarry[g])
          else $error("R4 skip carry, group %0d", g);
      end
    end
  end
endmodule

bind skip_adder skip_adder_chk #(
  .WIDTH       (WIDTH),
  .NUM_GROUPS  (NUM_GROUPS),
  .GROUP_SIZES (GROUP_SIZES)
) u_chk (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .sum      (sum),
  .carryOut (carryOut),
  .grpCarry (grpCarry),
  .grpProp  (grpProp)
);

// File: tb/sim_skip_adder.sv
module sim_skip_adder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sum;
  logic        carryOut;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // group widths from the requirements, least significant first
  int grpLo [5] = '{0, 2, 5, 9, 13};
  int grpSz [5] = '{2, 3, 4, 4, 3};

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_adder u0 (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sum      (sum),
    .carryOut (carryOut)
  );

  function automatic logic [15:0] grpMask(input int g);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < grpSz[g]; i++) m[grpLo[g] + i] = 1'b1;
    return m;
  endfunction

  task automatic applyAndCheck(input string tag, input logic [15:0] a,
                               input logic [15:0] b, input logic ci,
                               input logic [16:0] expected);
    @(negedge clk);
    opA = a; opB = b; carryIn = ci;
    #1;
    total++;
    if ({carryOut, sum} !== expected) begin
      bad++;
      $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h",
               tag, a, b, ci, {carryOut, sum}, expected);
    end
  endtask

  function automatic logic [16:0] refAdd(input logic [15:0] a, input logic [15:0] b,
                                         input logic ci);
    return 17'(a) + 17'(b) + 17'(ci);
  endfunction

  task automatic testZero();
    // R1: zero plus zero
    applyAndCheck("R1 zero", 16'h0000, 16'h0000, 1'b0, 17'h00000);
    applyAndCheck("R1 zero+cin", 16'h0000, 16'h0000, 1'b1, 17'h00001);
  endtask

  task automatic testFullCarry();
    // R2: one carry crosses every group
    applyAndCheck("R2 ones+cin", 16'hFFFF, 16'h0000, 1'b1, 17'h10000);
    applyAndCheck("R2 ones+one", 16'h0001, 16'hFFFF, 1'b0, 17'h10000);
    applyAndCheck("R2 ones no cin", 16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF);
  endtask

  task automatic testSkipPerGroup();
    // R3/R4: one group fully propagates, carry generated right below it
    for (int g = 0; g < 5; g++) begin
      logic [15:0] a, b;
      logic ci;
      a = grpMask(g);
      b = '0;
      ci = 1'b1;
      if (g > 0) begin
        a[grpLo[g]-1] = 1'b1;
        b[grpLo[g]-1] = 1'b1;
        ci = 1'b0;
      end
      applyAndCheck($sformatf("R4 skip group %0d", g), a, b, ci, refAdd(a, b, ci));
      applyAndCheck($sformatf("R3 split prop group %0d", g), a, ~a & grpMask(g), ci,
                    refAdd(a, ~a & grpMask(g), ci));
    end
  endtask

  task automatic testNoSkip();
    // R5: generate or kill at a group's top bit decides its outgoing carry
    for (int g = 0; g < 4; g++) begin
      logic [15:0] a, b;
      int top;
      top = grpLo[g] + grpSz[g] - 1;
      a = '0; b = '0;
      a[top] = 1'b1; b[top] = 1'b1;
      applyAndCheck($sformatf("R5 generate top g%0d", g), a, b, 1'b0, refAdd(a, b, 1'b0));
      a = 16'hFFFF; b = '0;
      a[top] = 1'b0;
      applyAndCheck($sformatf("R5 kill top g%0d", g), a, b, 1'b1, refAdd(a, b, 1'b1));
    end
  endtask

  task automatic testCarryEnds();
    // R6: carry-in enters group 0, carry-out leaves the top group
    applyAndCheck("R6 cin only", 16'h0001, 16'h0000, 1'b1, 17'h00002);
    applyAndCheck("R6 top generate", 16'h8000, 16'h8000, 1'b0, 17'h10000);
  endtask

  task automatic testBoundaries();
    // R7: carry crosses each default group boundary (bits 2, 5, 9, 13)
    applyAndCheck("R7 boundary 2", 16'h0003, 16'h0001, 1'b0, 17'h00004);
    applyAndCheck("R7 boundary 5", 16'h001F, 16'h0001, 1'b0, 17'h00020);
    applyAndCheck("R7 boundary 9", 16'h01FF, 16'h0001, 1'b0, 17'h00200);
    applyAndCheck("R7 boundary 13", 16'h1FFF, 16'h0001, 1'b0, 17'h02000);
  endtask

  task automatic testRandom();
    // R1: random operands with both carry-in values
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      for (int c = 0; c < 2; c++) begin
        applyAndCheck("R1 random", a, b, 1'(c), refAdd(a, b, 1'(c)));
      end
    end
  endtask

  task automatic testNoMemory();
    // R8: a result shows without a clock edge and ignores the previous pattern
    applyAndCheck("R8 setup", 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF);
    opA = 16'h0000; opB = 16'h0000; carryIn = 1'b0;
    #1;
    total++;
    if ({carryOut, sum} !== 17'h00000) begin
      bad++;
      $display("FAIL R8 no edge: actual=%h expected=%h", {carryOut, sum}, 17'h00000);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    total++;
    // R1: outputs right after start with all-zero inputs
    if ({carryOut, sum} !== 17'h00000) begin
      bad++;
      $display("FAIL R1 initial: actual=%h expected=%h", {carryOut, sum}, 17'h00000);
    end
    testZero();
    testFullCarry();
    testSkipPerGroup();
    testNoSkip();
    testCarryEnds();
    testBoundaries();
    testRandom();
    testNoMemory();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule